// File: doc/BRIEF.md
# Eight-Channel DAC Update Controller

This block is the digital front end of an eight-channel converter. A host shifts 32-bit command frames into it over a serial link made of a serial clock, an active-low frame select and a data line. The block keeps a staging (input) register and an output (DAC) register for each channel, and it presents the eight DAC register values as one flat output bus. A DAC register takes its input register's value at one of three moments: at the end of a frame, on a falling edge of the active-low load pin, or on a software command that updates all channels together.

A per-channel mask register sets how each channel treats the load pin. A channel with a mask bit of 0 waits for the pin. A channel with a mask bit of 1 acts as if the pin were tied low, so every write to that channel reaches its DAC register at the end of the frame. All serial inputs and the load pin are brought into the single system clock domain through synchronizers, and their edges are detected there. The system clock must run at least four times faster than the serial clock.

Top module: `dac_update_ctrl`

## Requirements
- R1: A frame is 32 bits, shifted in MSB first and sampled on falling serial clock edges while frame select is low. The command is frame bits 27:24, the channel address is bits 23:20 and the 16-bit data value is bits 19:4. Bits 31:28 have no effect.
- R2: If frame select rises before 32 bits have been shifted in, the frame is discarded. Any serial clock edges after the 32nd, while frame select stays low, are ignored.
- R3: Command 0000 writes the data value to the addressed input register. The DAC register of that channel also takes the value at the end of the frame, but only if the load pin is low at that moment or the channel's mask bit is 1.
- R4: Command 0001 copies the addressed channel's input register into its DAC register.
- R5: Command 0011 writes the data value to the addressed input register. It then loads all eight DAC registers from their input registers.
- R6: Command 0110 loads the mask from frame bits 7:0, with bit n belonging to channel n (channel 0 is bit 0). The mask resets to all zeros.
- R7: A falling edge on the load pin copies the input register into the DAC register of every channel whose mask bit is 0. Channels whose mask bit is 1 are left unchanged.
- R8: Address values 0 to 7 select the channel with that number. Values 8 to 14 select no channel. Value 15 selects all eight channels.
- R9: Any command other than 0000, 0001, 0011 and 0110 changes no register.
- R10: After reset, all input registers, all DAC registers and the mask are zero. Channel n drives dac_out bits [16n+15:16n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low hardware load pin |
| dac_out | output | CH*DW | The DAC register values; channel n occupies bits [n*DW +: DW] |

## Verification
The hardest case to reach from the ports is a masked channel whose input register holds a different value from its DAC register at the moment the load pin falls. A masked channel's DAC register normally follows every write, so the two values only differ in a narrow window. The stimulus creates that window on purpose: it writes the channel while it is unmasked and the pin is high, then sets the mask bit, then drops the pin. The check is that this channel's output stays put while the unmasked channels update. Random frames with random commands, addresses, top bits and trailing serial clocks are mixed with random pin toggles, and every step is compared against a bench model.

// File: rtl/dacu_pkg.sv
`timescale 1ns/1ps
package dacu_pkg;
  localparam int FRAME_BITS = 32;
  localparam int CMD_HI     = 27;
  localparam int ADDR_HI    = 23;
  localparam int DATA_HI    = 19;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 4;

  typedef enum logic [3:0] {
    CMD_WR_IN      = 4'b0000,
    CMD_UPD_ONE    = 4'b0001,
    CMD_WR_UPD_ALL = 4'b0011,
    CMD_SET_MASK   = 4'b0110
  } cmd_e;
endpackage

// File: rtl/dacu_sync.sv
`timescale 1ns/1ps
module dacu_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dacu_frame_rx.sv
`timescale 1ns/1ps
module dacu_frame_rx
  import dacu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_s,
  input  logic                  cs_n_s,
  input  logic                  sdi_s,
  output logic                  frm_vld,
  output logic [FRAME_BITS-1:0] frm_word
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);

  logic                  sclk_q;
  logic                  sclk_fall;
  logic [CW-1:0]         cnt_q;
  logic [FRAME_BITS-1:0] sh_q;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign frm_word  = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      frm_vld <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      frm_vld <= 1'b0;
      if (cs_n_s) begin
        cnt_q <= '0;
      end else if (sclk_fall && cnt_q < FULL) begin
        sh_q  <= {sh_q[FRAME_BITS-2:0], sdi_s};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) frm_vld <= 1'b1;
      end
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  // R2
  cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !frm_vld);
  // R1
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frm_vld |=> !frm_vld);
endmodule

// File: rtl/dacu_regbank.sv
`timescale 1ns/1ps
module dacu_regbank
  import dacu_pkg::*;
#(
  parameter int CH = 8,
  parameter int DW = DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frm_vld,
  input  logic [FRAME_BITS-1:0] frm_word,
  input  logic                  load_n_s,
  output logic [CH*DW-1:0]      dac_flat
);
  logic              load_q;
  logic              ld_fall;
  cmd_e              cmd;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     data;
  logic [CH-1:0]     sel;
  logic [CH-1:0]     mask_q;
  logic [DW-1:0]     inp_q [CH];
  logic [DW-1:0]     dac_q [CH];
  logic              unused_bits;

  assign ld_fall     = load_q & ~load_n_s;
  assign cmd         = cmd_e'(frm_word[CMD_HI -: 4]);
  assign addr        = frm_word[ADDR_HI -: ADDR_W];
  assign data        = frm_word[DATA_HI -: DW];
  assign unused_bits = ^frm_word[FRAME_BITS-1:CMD_HI+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= 1'b1;
      mask_q <= '0;
    end else begin
      load_q <= load_n_s;
      if (frm_vld && cmd == CMD_SET_MASK) mask_q <= frm_word[CH-1:0];
    end
  end

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(frm_vld && cmd == CMD_SET_MASK) |=> $stable(mask_q));

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic wr_in, upd, to_data;

    assign sel[c] = (addr == ADDR_W'(c)) || (addr == '1);

    always_comb begin
      wr_in   = frm_vld && sel[c] && (cmd == CMD_WR_IN || cmd == CMD_WR_UPD_ALL);
      upd     = 1'b0;
      to_data = 1'b0;
      if (frm_vld && cmd == CMD_WR_UPD_ALL) begin
        upd     = 1'b1;
        to_data = sel[c];
      end else if (frm_vld && cmd == CMD_UPD_ONE && sel[c]) begin
        upd = 1'b1;
      end else if (frm_vld && cmd == CMD_WR_IN && sel[c] && (mask_q[c] || !load_n_s)) begin
        upd     = 1'b1;
        to_data = 1'b1;
      end else if (ld_fall && !mask_q[c]) begin
        upd = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        inp_q[c] <= '0;
        dac_q[c] <= '0;
      end else begin
        if (wr_in) inp_q[c] <= data;
        if (upd)   dac_q[c] <= to_data ? data : inp_q[c];
      end
    end

    assign dac_flat[c*DW +: DW] = dac_q[c];

    // R3
    in_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !frm_vld |=> $stable(inp_q[c]));
    // R7
    dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!frm_vld && !ld_fall) |=> $stable(dac_q[c]));
    // R7
    mask_pin_chk: assert property (@(posedge clk) disable iff (rst)
      (ld_fall && !frm_vld && mask_q[c]) |=> $stable(dac_q[c]));
  end
endmodule

// File: rtl/dac_update_ctrl.sv
`timescale 1ns/1ps
module dac_update_ctrl
  import dacu_pkg::*;
#(
  parameter int CH = 8,
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic             load_n,
  output logic [CH*DW-1:0] dac_out
);
  logic [3:0]            raw, syn;
  logic                  frm_vld;
  logic [FRAME_BITS-1:0] frm_word;

  assign raw = {load_n, sdi, cs_n, sclk};

  dacu_sync #(.W(4), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  dacu_frame_rx u_rx (
    .clk(clk), .rst(rst),
    .sclk_s(syn[0]), .cs_n_s(syn[1]), .sdi_s(syn[2]),
    .frm_vld(frm_vld), .frm_word(frm_word)
  );

  dacu_regbank #(.CH(CH), .DW(DW)) u_bank (
    .clk(clk), .rst(rst),
    .frm_vld(frm_vld), .frm_word(frm_word),
    .load_n_s(syn[3]), .dac_flat(dac_out)
  );
endmodule

// File: tb/sim_dac_update_ctrl.sv
`timescale 1ns/1ps
module sim_dac_update_ctrl;
  localparam int CH = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, load_n = 1'b1;
  logic [CH*DW-1:0] dac_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] m_in  [CH];
  logic [15:0] m_dac [CH];
  logic [7:0]  m_mask;

  always #2 clk = ~clk;

  dac_update_ctrl #(.CH(CH), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .load_n(load_n), .dac_out(dac_out)
  );

  function automatic logic [CH*DW-1:0] pack_exp();
    logic [CH*DW-1:0] v;
    for (int c = 0; c < CH; c++) v[c*DW +: DW] = m_dac[c];
    return v;
  endfunction

  function automatic logic [31:0] mkw(logic [3:0] cmd, logic [3:0] addr, logic [15:0] data);
    logic [31:0] w = $urandom;
    w[27:24] = cmd;
    w[23:20] = addr;
    w[19:4]  = data;
    return w;
  endfunction

  function automatic bit hit(logic [3:0] addr, int c);
    return (addr == 4'(c)) || (addr == 4'hF);
  endfunction

  function automatic void model_frame(logic [31:0] w);
    logic [3:0] cmd = w[27:24];
    logic [3:0] addr = w[23:20];
    logic [15:0] d = w[19:4];
    case (cmd)
      4'b0000: for (int c = 0; c < CH; c++) if (hit(addr, c)) begin
                 m_in[c] = d;
                 if (!load_n || m_mask[c]) m_dac[c] = d;
               end
      4'b0001: for (int c = 0; c < CH; c++) if (hit(addr, c)) m_dac[c] = m_in[c];
      4'b0011: for (int c = 0; c < CH; c++) begin
                 if (hit(addr, c)) m_in[c] = d;
                 m_dac[c] = m_in[c];
               end
      4'b0110: m_mask = w[7:0];
      default: ;
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req);
    logic [CH*DW-1:0] e = pack_exp();
    checks++;
    if (dac_out !== e) begin
      fails++;
      $display("FAIL %s: dac_out=%h expected=%h", req, dac_out, e);
    end
  endtask

  task automatic shift(logic [31:0] w, int nbits, int extra);
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nbits + extra; i++) begin
      sdi = (i < 32) ? w[31-i] : 1'($urandom);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(4);
    end
    tick(2);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic frame(logic [31:0] w, string req);
    shift(w, 32, $urandom % 4);
    model_frame(w);
    check(req);
  endtask

  task automatic set_load(logic v, string req);
    if (load_n && !v)
      for (int c = 0; c < CH; c++) if (!m_mask[c]) m_dac[c] = m_in[c];
    load_n = v;
    tick(10);
    check(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int c = 0; c < CH; c++) begin m_in[c] = '0; m_dac[c] = '0; end
    m_mask = '0;
    tick(5);
    rst = 1'b0;
    tick(5);
    check("R10 reset");

    // R3: pin high, write waits; R7: pin falling edge moves it
    frame(mkw(4'h0, 4'd2, 16'hA5A5), "R3 write held by pin");
    set_load(1'b0, "R7 pin edge");
    frame(mkw(4'h0, 4'd5, 16'h1234), "R3 pin low immediate");
    set_load(1'b1, "R7 pin rise no effect");
    // R4
    frame(mkw(4'h0, 4'd2, 16'h5A5A), "R3 stage ch2");
    frame(mkw(4'h1, 4'd2, 16'hFFFF), "R4 copy one");
    // R6 + R7: masked channel with stale DAC ignores the pin
    frame(mkw(4'h0, 4'd3, 16'h3333), "R3 stage ch3");
    frame(mkw(4'h0, 4'd1, 16'h1111), "R3 stage ch1");
    frame(mkw(4'h6, 4'd9, {8'h00, 8'h00}) | 32'h0000_0089, "R6 set mask");
    set_load(1'b0, "R7 masked ch3 keeps old value");
    set_load(1'b1, "R7 release");
    frame(mkw(4'h0, 4'd0, 16'hC0DE), "R6 masked ch0 updates at frame end");
    // R8
    frame(mkw(4'h0, 4'd9, 16'hDEAD), "R8 address 9 selects none");
    frame(mkw(4'h0, 4'd14, 16'hDEAD), "R8 address 14 selects none");
    frame(mkw(4'h0, 4'hF, 16'h7777), "R8 address 15 selects all");
    // R5
    frame(mkw(4'h3, 4'd4, 16'h4444), "R5 write and update all");
    // R9 with pin low
    set_load(1'b0, "R7 edge before unused cmds");
    frame(mkw(4'h7, 4'd1, 16'hBEEF), "R9 unused 0111");
    frame(mkw(4'hF, 4'hF, 16'hBEEF), "R9 unused 1111");
    set_load(1'b1, "R7 release");
    // R2: truncated frame
    shift(mkw(4'h3, 4'hF, 16'h9999), 20, 0);
    check("R2 truncated frame discarded");
    shift(mkw(4'h3, 4'hF, 16'h9999), 31, 0);
    check("R2 31-bit frame discarded");
    frame(mkw(4'h6, 4'd0, 16'h0000), "R6 clear mask");

    // R1: random frames, random top bits, trailing clocks, pin toggles
    for (int k = 0; k < 160; k++) begin
      int sel = $urandom % 10;
      logic [3:0] cmd;
      case ($urandom % 6)
        0, 1: cmd = 4'h0;
        2:    cmd = 4'h1;
        3:    cmd = 4'h3;
        4:    cmd = 4'h6;
        default: cmd = 4'($urandom);
      endcase
      if (sel < 3) set_load(~load_n, "R7 random pin toggle");
      else frame(mkw(cmd, 4'($urandom), 16'($urandom)), "R1 random frame");
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule